// File: doc/BRIEF.md
# Split-Address Load Disambiguator

This block sits at the front of a load/store queue whose effective addresses reach it in two pieces. A narrow low-order slice comes first over a fast path. It carries the cache set index, a few TLB index bits and the queue entry it belongs to. The remaining high-order bits come later over a slow, wide path. Loads and stores are allocated into a circular queue in program order. Each load is then checked only against the stores that are older than it.

A load whose low-order bits collide with no older store is released to start its cache and TLB array read on the cycle after its early slice lands. A load whose low-order bits do collide is held. Once its own high bits and those of every colliding store have arrived, the block emits a full-compare event. A false alarm releases the load one cycle later. A true dependence keeps the load parked until the store retires. A started load whose high bits are present gets a one-cycle translation-select/tag-compare event.

Top module: `splitAddrDisambig`

## Requirements
- R1: The early packet is 18 bits: bits [7:0] are the cache set index, bits [11:8] the TLB index and bits [17:12] the queue entry. A cache-start event reports the set and TLB index of the load it releases.
- R2: Allocation fills entries in program order starting at entry 0 after reset and wrapping modulo 64. Retirement frees the oldest entry. Age is judged relative to the oldest entry, so ordering stays correct across the wrap.
- R3: A load whose set and TLB bits match those of no older store gets a cache-start pulse in the cycle right after the edge that captured its early slice.
- R4: An older store whose early slice has not arrived blocks the load from starting. The load starts in the cycle after that store's early slice arrives, if the slice does not match.
- R5: Stores younger than a load never block it and never match it, arrived or not.
- R6: A load whose low bits match an older store does not start. A single full-compare pulse appears once the load's high bits and those of every matching older store are present. The pulse reports whether a complete address match exists.
- R7: If the full compare finds no true match, the load gets its cache-start pulse in the next cycle.
- R8: If the full compare finds a true match, the load gets no cache-start while the store remains. It starts in the cycle after the store retires.
- R9: A started load gets a tag-select pulse one cycle after both its start and its high bits are in place.
- R10: Each load gets at most one cache-start pulse.
- R11: After reset, the queue is empty and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate next entry in program order |
| allocIsStore | input | 1 | Allocated operation is a store |
| retireValid | input | 1 | Free the oldest entry |
| earlyValid | input | 1 | Early slice present |
| earlyPkt | input | 18 | Early slice: {entry, tlb index, set index} |
| lateValid | input | 1 | High-order bits present |
| lateId | input | 6 | Entry of the high-order bits |
| lateHigh | input | 20 | High-order address bits |
| cacheStartValid | output | 1 | Load released to cache/TLB arrays |
| cacheStartId | output | 6 | Entry of the released load |
| cacheStartSet | output | 8 | Set index of the released load |
| cacheStartTlb | output | 4 | TLB index of the released load |
| fullCmpValid | output | 1 | Full-address compare performed |
| fullCmpId | output | 6 | Entry of the compared load |
| fullCmpMatch | output | 1 | Compare found a true dependence |
| tagSelValid | output | 1 | Translation select / tag compare cycle |
| tagSelId | output | 6 | Entry of that load |

## Verification
The bench targets the ordering corners. In the first, an older store is still missing its early slice; a design without this check would release the load too soon. Younger stores must not be treated as older, which would stall a load for nothing. After the queue wraps, the oldest entry has a high index and the load a low one; judging age by raw index would let that load bypass a store that has not arrived. The bench also drives a false-alarm partial match and a true match. A design that got these wrong would either never release the load, or release it before the store retires.

// File: rtl/ldqPkg.sv
package ldqPkg;
  typedef struct packed {
    logic allocEn;
    logic allocIsStore;
    logic retireEn;
  } ctlStrobes_t;
endpackage

// File: rtl/ldqDatapath.sv
module ldqDatapath #(
  parameter int SET_W  = 8,
  parameter int TLB_W  = 4,
  parameter int ID_W   = 6,
  parameter int HIGH_W = 20,
  localparam int DEPTH = 1 << ID_W,
  localparam int LOW_W = SET_W + TLB_W,
  localparam int PKT_W = LOW_W + ID_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ldqPkg::ctlStrobes_t   strobes,
  input  logic [ID_W-1:0]       allocIdx,
  input  logic [ID_W-1:0]       headIdx,
  input  logic                  earlyValid,
  input  logic [PKT_W-1:0]      earlyPkt,
  input  logic                  lateValid,
  input  logic [ID_W-1:0]       lateId,
  input  logic [HIGH_W-1:0]     lateHigh,
  input  logic [ID_W-1:0]       startIdx,
  output logic [DEPTH-1:0]      validVec,
  output logic [DEPTH-1:0]      storeVec,
  output logic [DEPTH-1:0]      earlyVec,
  output logic [DEPTH-1:0]      lateVec,
  output logic [DEPTH-1:0]      blockVec,
  output logic [DEPTH-1:0]      partialVec,
  output logic [DEPTH-1:0]      highReadyVec,
  output logic [DEPTH-1:0]      fullHitVec,
  output logic [SET_W-1:0]      startSet,
  output logic [TLB_W-1:0]      startTlb
);
  logic [LOW_W-1:0]  lowQ  [DEPTH];
  logic [HIGH_W-1:0] highQ [DEPTH];
  logic [ID_W-1:0]   earlyId;
  logic [LOW_W-1:0]  earlyLow;

  assign earlyId  = earlyPkt[PKT_W-1:LOW_W];
  assign earlyLow = earlyPkt[LOW_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      storeVec <= '0;
      earlyVec <= '0;
      lateVec  <= '0;
    end else begin
      if (strobes.retireEn) validVec[headIdx] <= 1'b0;
      if (earlyValid && validVec[earlyId]) earlyVec[earlyId] <= 1'b1;
      if (lateValid && validVec[lateId]) lateVec[lateId] <= 1'b1;
      if (strobes.allocEn) begin
        validVec[allocIdx] <= 1'b1;
        storeVec[allocIdx] <= strobes.allocIsStore;
        earlyVec[allocIdx] <= 1'b0;
        lateVec[allocIdx]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (earlyValid) lowQ[earlyId] <= earlyLow;
    if (lateValid) highQ[lateId] <= lateHigh;
  end

  // Older-store compare matrix, age taken relative to the head entry
  always_comb begin
    logic [ID_W-1:0] ageI, ageJ;
    logic stOlder, pMatch;
    logic [DEPTH-1:0] highPend;
    blockVec   = '0;
    partialVec = '0;
    fullHitVec = '0;
    highPend   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ageI = ID_W'(i) - headIdx;
      for (int j = 0; j < DEPTH; j++) begin
        ageJ    = ID_W'(j) - headIdx;
        stOlder = validVec[j] && storeVec[j] && (ageJ < ageI);
        pMatch  = stOlder && earlyVec[j] && (lowQ[j] == lowQ[i]);
        if (stOlder && !earlyVec[j]) blockVec[i] = 1'b1;
        if (pMatch) partialVec[i] = 1'b1;
        if (pMatch && !lateVec[j]) highPend[i] = 1'b1;
        if (pMatch && lateVec[j] && lateVec[i] && highQ[j] == highQ[i])
          fullHitVec[i] = 1'b1;
      end
    end
    highReadyVec = lateVec & ~highPend;
  end

  assign startSet = lowQ[startIdx][SET_W-1:0];
  assign startTlb = lowQ[startIdx][LOW_W-1:SET_W];
endmodule

// File: rtl/ldqControl.sv
module ldqControl #(
  parameter int ID_W = 6,
  localparam int DEPTH = 1 << ID_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                allocValid,
  input  logic                allocIsStore,
  input  logic                retireValid,
  input  logic [DEPTH-1:0]    validVec,
  input  logic [DEPTH-1:0]    storeVec,
  input  logic [DEPTH-1:0]    earlyVec,
  input  logic [DEPTH-1:0]    lateVec,
  input  logic [DEPTH-1:0]    blockVec,
  input  logic [DEPTH-1:0]    partialVec,
  input  logic [DEPTH-1:0]    highReadyVec,
  input  logic [DEPTH-1:0]    fullHitVec,
  output ldqPkg::ctlStrobes_t strobes,
  output logic [ID_W-1:0]     allocIdx,
  output logic [ID_W-1:0]     headIdx,
  output logic                cacheStartValid,
  output logic [ID_W-1:0]     cacheStartId,
  output logic                fullCmpValid,
  output logic [ID_W-1:0]     fullCmpId,
  output logic                fullCmpMatch,
  output logic                tagSelValid,
  output logic [ID_W-1:0]     tagSelId
);
  logic [ID_W:0]      count;
  logic [DEPTH-1:0]   startedQ, cmpDoneQ, selDoneQ;
  logic [DEPTH-1:0]   loadVec, startCand, cmpCand, selCand;

  assign strobes.allocEn      = allocValid && (count < (ID_W+1)'(DEPTH));
  assign strobes.allocIsStore = allocIsStore;
  assign strobes.retireEn     = retireValid && (count != '0);

  assign loadVec   = validVec & ~storeVec & earlyVec;
  assign startCand = loadVec & ~startedQ & ~blockVec & (~partialVec | (cmpDoneQ & ~fullHitVec));
  assign cmpCand   = loadVec & ~startedQ & ~cmpDoneQ & ~blockVec & partialVec & highReadyVec;
  assign selCand   = validVec & ~storeVec & startedQ & lateVec & ~selDoneQ;

  always_comb begin
    cacheStartValid = |startCand;
    fullCmpValid    = |cmpCand;
    tagSelValid     = |selCand;
    cacheStartId    = '0;
    fullCmpId       = '0;
    tagSelId        = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (startCand[i]) cacheStartId = ID_W'(i);
      if (cmpCand[i])   fullCmpId    = ID_W'(i);
      if (selCand[i])   tagSelId     = ID_W'(i);
    end
    fullCmpMatch = fullCmpValid && fullHitVec[fullCmpId];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocIdx <= '0;
      headIdx  <= '0;
      count    <= '0;
      startedQ <= '0;
      cmpDoneQ <= '0;
      selDoneQ <= '0;
    end else begin
      if (strobes.allocEn)  allocIdx <= allocIdx + 1'b1;
      if (strobes.retireEn) headIdx  <= headIdx + 1'b1;
      count <= count + (ID_W+1)'(strobes.allocEn) - (ID_W+1)'(strobes.retireEn);
      if (cacheStartValid) startedQ[cacheStartId] <= 1'b1;
      if (fullCmpValid)    cmpDoneQ[fullCmpId]    <= 1'b1;
      if (tagSelValid)     selDoneQ[tagSelId]     <= 1'b1;
      if (strobes.allocEn) begin
        startedQ[allocIdx] <= 1'b0;
        cmpDoneQ[allocIdx] <= 1'b0;
        selDoneQ[allocIdx] <= 1'b0;
      end
    end
  end

  // R4
  start_unblocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    cacheStartValid |-> !blockVec[cacheStartId]);
  // R8
  start_no_truedep_chk: assert property (@(posedge clk) disable iff (!rstN)
    cacheStartValid |-> !fullHitVec[cacheStartId]);
  // R6
  cmp_needs_partial_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullCmpValid |-> (partialVec[fullCmpId] && lateVec[fullCmpId]));
  // R10
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cacheStartValid |=> !(cacheStartValid && cacheStartId == $past(cacheStartId)));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= (ID_W+1)'(DEPTH));
endmodule

// File: rtl/splitAddrDisambig.sv
module splitAddrDisambig #(
  parameter int SET_W  = 8,
  parameter int TLB_W  = 4,
  parameter int ID_W   = 6,
  parameter int HIGH_W = 20,
  localparam int DEPTH = 1 << ID_W,
  localparam int PKT_W = SET_W + TLB_W + ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              allocIsStore,
  input  logic              retireValid,
  input  logic              earlyValid,
  input  logic [PKT_W-1:0]  earlyPkt,
  input  logic              lateValid,
  input  logic [ID_W-1:0]   lateId,
  input  logic [HIGH_W-1:0] lateHigh,
  output logic              cacheStartValid,
  output logic [ID_W-1:0]   cacheStartId,
  output logic [SET_W-1:0]  cacheStartSet,
  output logic [TLB_W-1:0]  cacheStartTlb,
  output logic              fullCmpValid,
  output logic [ID_W-1:0]   fullCmpId,
  output logic              fullCmpMatch,
  output logic              tagSelValid,
  output logic [ID_W-1:0]   tagSelId
);
  ldqPkg::ctlStrobes_t strobes;
  logic [ID_W-1:0]  allocIdx, headIdx;
  logic [DEPTH-1:0] validVec, storeVec, earlyVec, lateVec;
  logic [DEPTH-1:0] blockVec, partialVec, highReadyVec, fullHitVec;

  ldqDatapath #(.SET_W(SET_W), .TLB_W(TLB_W), .ID_W(ID_W), .HIGH_W(HIGH_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .allocIdx(allocIdx), .headIdx(headIdx),
    .earlyValid(earlyValid), .earlyPkt(earlyPkt), .lateValid(lateValid),
    .lateId(lateId), .lateHigh(lateHigh), .startIdx(cacheStartId),
    .validVec(validVec), .storeVec(storeVec), .earlyVec(earlyVec), .lateVec(lateVec),
    .blockVec(blockVec), .partialVec(partialVec), .highReadyVec(highReadyVec),
    .fullHitVec(fullHitVec), .startSet(cacheStartSet), .startTlb(cacheStartTlb)
  );

  ldqControl #(.ID_W(ID_W)) uCtl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocIsStore(allocIsStore),
    .retireValid(retireValid), .validVec(validVec), .storeVec(storeVec),
    .earlyVec(earlyVec), .lateVec(lateVec), .blockVec(blockVec),
    .partialVec(partialVec), .highReadyVec(highReadyVec), .fullHitVec(fullHitVec),
    .strobes(strobes), .allocIdx(allocIdx), .headIdx(headIdx),
    .cacheStartValid(cacheStartValid), .cacheStartId(cacheStartId),
    .fullCmpValid(fullCmpValid), .fullCmpId(fullCmpId), .fullCmpMatch(fullCmpMatch),
    .tagSelValid(tagSelValid), .tagSelId(tagSelId)
  );
endmodule

// File: tb/tb_splitAddrDisambig.sv
`timescale 1ns/1ps
module tb_splitAddrDisambig;
  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, allocIsStore = 0, retireValid = 0;
  logic earlyValid = 0, lateValid = 0;
  logic [17:0] earlyPkt = '0;
  logic [5:0]  lateId = '0;
  logic [19:0] lateHigh = '0;
  logic        cacheStartValid, fullCmpValid, fullCmpMatch, tagSelValid;
  logic [5:0]  cacheStartId, fullCmpId, tagSelId;
  logic [7:0]  cacheStartSet;
  logic [3:0]  cacheStartTlb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  splitAddrDisambig dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    allocValid = 0; retireValid = 0; earlyValid = 0; lateValid = 0;
  endtask
  task automatic alloc(input bit st);
    allocValid = 1; allocIsStore = st; step();
  endtask
  task automatic retire();
    retireValid = 1; step();
  endtask
  task automatic early(input int id, input int set, input int tlb);
    earlyValid = 1; earlyPkt = {6'(id), 4'(tlb), 8'(set)}; step();
  endtask
  task automatic late(input int id, input int hi);
    lateValid = 1; lateId = 6'(id); lateHigh = 20'(hi); step();
  endtask
  task automatic doReset();
    rstN = 0; step(); step(); rstN = 1;
  endtask

  task automatic tReset();
    doReset();
    chk(!cacheStartValid && !fullCmpValid && !tagSelValid, "R11 outputs idle", cacheStartValid, 0);
  endtask

  task automatic tFreeLoad();
    doReset();
    alloc(1); alloc(0);
    early(0, 8'h11, 1);
    early(1, 8'hA5, 4'hC);
    chk(cacheStartValid && cacheStartId == 1, "R3 start after early", cacheStartId, 1);
    chk(cacheStartSet == 8'hA5 && cacheStartTlb == 4'hC, "R1 set/tlb fields", cacheStartSet, 8'hA5);
    step();
    chk(!cacheStartValid, "R10 single start", cacheStartValid, 0);
    late(1, 20'h123);
    chk(tagSelValid && tagSelId == 1, "R9 tag select after high", tagSelId, 1);
    step();
    chk(!tagSelValid, "R9 tag select one pulse", tagSelValid, 0);
  endtask

  task automatic tBlocked();
    doReset();
    alloc(1); alloc(0);
    early(1, 8'h22, 3);
    chk(!cacheStartValid, "R4 blocked by unknown store", cacheStartValid, 0);
    early(0, 8'h23, 3);
    chk(cacheStartValid && cacheStartId == 1, "R4 start after store slice", cacheStartId, 1);
  endtask

  task automatic tYounger();
    doReset();
    alloc(0); alloc(1);
    early(0, 8'h44, 5);
    chk(cacheStartValid && cacheStartId == 0, "R5 younger store ignored", cacheStartId, 0);
  endtask

  task automatic tFalseAlarm();
    doReset();
    alloc(1); alloc(0);
    early(0, 8'h33, 2);
    early(1, 8'h33, 2);
    chk(!cacheStartValid && !fullCmpValid, "R6 partial match waits", cacheStartValid, 0);
    late(1, 20'hAAAA);
    chk(!fullCmpValid, "R6 compare waits for store high", fullCmpValid, 0);
    late(0, 20'hBBBB);
    chk(fullCmpValid && fullCmpId == 1 && !fullCmpMatch, "R6 compare no match", fullCmpMatch, 0);
    chk(!cacheStartValid, "R7 no start in compare cycle", cacheStartValid, 0);
    step();
    chk(cacheStartValid && cacheStartId == 1, "R7 start after false alarm", cacheStartId, 1);
    chk(!fullCmpValid, "R6 single compare pulse", fullCmpValid, 0);
    step();
    chk(tagSelValid && tagSelId == 1, "R9 tag select after start", tagSelId, 1);
  endtask

  task automatic tTrueDep();
    doReset();
    alloc(1); alloc(0);
    early(0, 8'h55, 7);
    early(1, 8'h55, 7);
    late(0, 20'h777);
    late(1, 20'h777);
    chk(fullCmpValid && fullCmpMatch, "R6 compare true match", fullCmpMatch, 1);
    step(); step();
    chk(!cacheStartValid, "R8 held on true dep", cacheStartValid, 0);
    retire();
    chk(cacheStartValid && cacheStartId == 1, "R8 start after store retires", cacheStartId, 1);
    step();
    chk(!cacheStartValid, "R10 no second start", cacheStartValid, 0);
  endtask

  task automatic tWrap();
    doReset();
    for (int k = 0; k < 62; k++) begin alloc(0); retire(); end
    alloc(1); alloc(1); alloc(0);   // entries 62, 63, 0
    early(0, 8'h66, 1);
    early(62, 8'h67, 1);
    chk(!cacheStartValid, "R2 wrapped age blocks", cacheStartValid, 0);
    early(63, 8'h68, 1);
    chk(cacheStartValid && cacheStartId == 0, "R2 wrapped load starts", cacheStartId, 0);
  endtask

  initial begin
    step();
    tReset();
    tFreeLoad();
    tBlocked();
    tYounger();
    tFalseAlarm();
    tTrueDep();
    tWrap();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule